// File: doc/BRIEF.md
# Reed-Solomon Error Applier

This block takes the result of a Reed-Solomon decode over a 512-byte data block and fixes the buffer in place. The decoder supplies an error count, an uncorrectable flag and up to four error reports. Each report holds a 1-based 9-bit symbol position and a 9-bit error pattern. The symbols are 9 bits wide and packed into a stream of 8-bit bytes, so one symbol can span two neighbouring bytes. The block works out which byte or bytes a report covers and the bit shift inside them. It then XORs the pattern into the buffer through a single byte-wide RAM port. Each byte change is a read, then an XOR, then a write.

A caller pulses `start` while the block is idle. The block registers every input in that cycle, keeps `busy` high while it works, and gives a one-cycle `done`. `fail` is valid in the same cycle as `done`. If the uncorrectable flag is set, the block finishes with `fail` high and never touches the RAM. A report that would land past the end of the block is dropped. A report whose symbol ends on the last byte updates only that byte.

Top module: `rs_err_apply`

## Requirements
- R1: A `start` while idle captures `err_cnt`, `uncorr`, `rep_idx` and `rep_mask`. Changes to those inputs afterwards, and any `start` while busy, do not affect the run.
- R2: With `uncorr` = 1, `done` and `fail` are both 1 exactly one cycle after the start cycle, and `ram_wr` never asserts.
- R3: With a count of 0, `done` = 1 and `fail` = 0 one cycle after the start cycle, with no RAM access. A count above 4 is treated as 4.
- R4: With count N, reports N-1 down to 0 are applied in that order. Report k occupies bits [9k+8:9k] of `rep_idx` and `rep_mask`. Reports k >= N are ignored.
- R5: For symbol index i, the block uses p = i - 1 modulo 512. The byte offset is p + (p >> 3), and the 16-bit pattern is the mask shifted left by p mod 8.
- R6: Each byte update drives `ram_rd` with the address in one cycle. In the next cycle it drives `ram_wr` to the same address with `ram_rdata` XOR the pattern byte. `ram_rdata` has one cycle of read latency.
- R7: Bits [7:0] of the pattern go to the byte at the offset. Bits [15:8] go to offset + 1, but only when the offset is below 511, and that write happens even when the byte is zero.
- R8: A report whose offset is 512 or more makes no RAM access. This includes index 0, which wraps to offset 574.
- R9: `busy` is 1 from the cycle after an accepted start up to the `done` cycle. It is 0 during `done`. `done` lasts exactly one cycle, and `fail` is 1 only together with `done`.
- R10: After reset, `busy`, `done`, `fail`, `ram_rd` and `ram_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a correction run (accepted only when idle) |
| err_cnt | input | 3 | Number of valid reports (clamped to 4) |
| uncorr | input | 1 | Decoder reports an uncorrectable block |
| rep_idx | input | 36 | Four 1-based symbol positions, report k at [9k+8:9k] |
| rep_mask | input | 36 | Four 9-bit error patterns, report k at [9k+8:9k] |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Uncorrectable result, valid with done |
| ram_addr | output | 9 | Byte address of the buffer |
| ram_rd | output | 1 | Read strobe, data on ram_rdata next cycle |
| ram_wr | output | 1 | Write strobe |
| ram_wdata | output | 8 | Corrected byte |
| ram_rdata | input | 8 | Byte read from the buffer |

## Verification
The bench targets the end of the buffer. Symbol 455 covers bytes 510 and 511. Symbol 456 ends on byte 511, so a design with a wrong bound would write byte 512 or drop the single write. Symbol 457, and index 0 which wraps, must be skipped; a design without the skip would write past the end or alias back to low addresses. The bench also checks that the first write goes to the highest-numbered active report, which catches a design that walks the reports in the wrong direction. It checks that counts of 5 to 7 apply four reports, and that an uncorrectable block issues no writes. A further test changes the inputs and pulses `start` while the block is busy; a design that does not hold its inputs would apply the wrong pattern.

// File: rtl/rs_apply_pkg.sv
package rs_apply_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_LO = 3'd1,
        ST_WR_LO = 3'd2,
        ST_RD_HI = 3'd3,
        ST_WR_HI = 3'd4,
        ST_FIN   = 3'd5
    } apply_st_e;

endpackage

// File: rtl/rs_sym_locate.sv
// Maps a 1-based packed-symbol index to a byte offset and a two-byte pattern.
module rs_sym_locate #(
    parameter int IDX_W      = 9,
    parameter int MASK_W     = 9,
    parameter int DATA_BYTES = 512,
    localparam int OFF_W     = IDX_W + 1,
    localparam int SPAN_W    = 2 * rs_apply_pkg::BYTE_W
) (
    input  logic [IDX_W-1:0]                idx,
    input  logic [MASK_W-1:0]               mask,
    output logic [OFF_W-1:0]                offset,
    output logic [rs_apply_pkg::BYTE_W-1:0] pat_lo,
    output logic [rs_apply_pkg::BYTE_W-1:0] pat_hi,
    output logic                            hit,
    output logic                            pair
);
    logic [IDX_W-1:0]  pos;
    logic [SPAN_W-1:0] spread;

    always_comb begin
        pos    = idx - IDX_W'(1);
        offset = OFF_W'(pos) + OFF_W'(pos >> 3);
        spread = SPAN_W'(mask) << pos[2:0];
        pat_lo = spread[rs_apply_pkg::BYTE_W-1:0];
        pat_hi = spread[SPAN_W-1:rs_apply_pkg::BYTE_W];
        hit    = offset < OFF_W'(DATA_BYTES);
        pair   = offset < OFF_W'(DATA_BYTES - 1);
    end

endmodule

// File: rtl/rs_report_pick.sv
// Selects one report out of the flattened report vectors.
module rs_report_pick #(
    parameter int NREP   = 4,
    parameter int IDX_W  = 9,
    parameter int MASK_W = 9,
    localparam int SEL_W = (NREP > 1) ? $clog2(NREP) : 1
) (
    input  logic [NREP*IDX_W-1:0]  idx_flat,
    input  logic [NREP*MASK_W-1:0] mask_flat,
    input  logic [SEL_W-1:0]       sel,
    output logic [IDX_W-1:0]       idx,
    output logic [MASK_W-1:0]      mask
);
    logic [IDX_W-1:0]  idx_arr  [NREP];
    logic [MASK_W-1:0] mask_arr [NREP];

    for (genvar k = 0; k < NREP; k++) begin : g_unpack
        assign idx_arr[k]  = idx_flat[k*IDX_W +: IDX_W];
        assign mask_arr[k] = mask_flat[k*MASK_W +: MASK_W];
    end

    always_comb begin
        idx  = idx_arr[0];
        mask = mask_arr[0];
        for (int k = 1; k < NREP; k++) begin
            if (SEL_W'(k) == sel) begin
                idx  = idx_arr[k];
                mask = mask_arr[k];
            end
        end
    end

endmodule

// File: rtl/rs_err_apply.sv
module rs_err_apply #(
    parameter int NREP       = 4,
    parameter int IDX_W      = 9,
    parameter int MASK_W     = 9,
    parameter int DATA_BYTES = 512,
    localparam int ADDR_W    = $clog2(DATA_BYTES),
    localparam int CNT_W     = $clog2(NREP + 1),
    localparam int SEL_W     = (NREP > 1) ? $clog2(NREP) : 1,
    localparam int OFF_W     = IDX_W + 1,
    localparam int BW        = rs_apply_pkg::BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CNT_W-1:0]       err_cnt,
    input  logic                   uncorr,
    input  logic [NREP*IDX_W-1:0]  rep_idx,
    input  logic [NREP*MASK_W-1:0] rep_mask,
    output logic                   busy,
    output logic                   done,
    output logic                   fail,
    output logic [ADDR_W-1:0]      ram_addr,
    output logic                   ram_rd,
    output logic                   ram_wr,
    output logic [BW-1:0]          ram_wdata,
    input  logic [BW-1:0]          ram_rdata
);
    import rs_apply_pkg::*;

    typedef struct packed {
        apply_st_e             st;
        logic [SEL_W-1:0]      cur;
        logic                  fail;
        logic [NREP*IDX_W-1:0] idx;
        logic [NREP*MASK_W-1:0] msk;
    } ctx_t;

    ctx_t r_d, r_q;

    logic [IDX_W-1:0]  sel_idx;
    logic [MASK_W-1:0] sel_mask;
    logic [OFF_W-1:0]  loc_off;
    logic [BW-1:0]     loc_lo, loc_hi;
    logic              loc_hit, loc_pair;
    logic [CNT_W-1:0]  cnt_eff;

    rs_report_pick #(
        .NREP  (NREP),
        .IDX_W (IDX_W),
        .MASK_W(MASK_W)
    ) u_pick (
        .idx_flat (r_q.idx),
        .mask_flat(r_q.msk),
        .sel      (r_q.cur),
        .idx      (sel_idx),
        .mask     (sel_mask)
    );

    rs_sym_locate #(
        .IDX_W     (IDX_W),
        .MASK_W    (MASK_W),
        .DATA_BYTES(DATA_BYTES)
    ) u_loc (
        .idx   (sel_idx),
        .mask  (sel_mask),
        .offset(loc_off),
        .pat_lo(loc_lo),
        .pat_hi(loc_hi),
        .hit   (loc_hit),
        .pair  (loc_pair)
    );

    assign cnt_eff = (err_cnt > CNT_W'(NREP)) ? CNT_W'(NREP) : err_cnt;

    always_comb begin
        r_d       = r_q;
        ram_rd    = 1'b0;
        ram_wr    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.idx  = rep_idx;
                    r_d.msk  = rep_mask;
                    r_d.fail = uncorr;
                    r_d.cur  = SEL_W'(cnt_eff - CNT_W'(1));
                    if (uncorr || (cnt_eff == '0)) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: begin
                if (loc_hit) begin
                    ram_rd   = 1'b1;
                    ram_addr = ADDR_W'(loc_off);
                    r_d.st   = ST_WR_LO;
                end else if (r_q.cur == '0) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.cur = r_q.cur - SEL_W'(1);
                end
            end
            ST_WR_LO: begin
                ram_wr    = 1'b1;
                ram_addr  = ADDR_W'(loc_off);
                ram_wdata = ram_rdata ^ loc_lo;
                if (loc_pair) begin
                    r_d.st = ST_RD_HI;
                end else if (r_q.cur == '0) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.cur = r_q.cur - SEL_W'(1);
                    r_d.st  = ST_RD_LO;
                end
            end
            ST_RD_HI: begin
                ram_rd   = 1'b1;
                ram_addr = ADDR_W'(loc_off + OFF_W'(1));
                r_d.st   = ST_WR_HI;
            end
            ST_WR_HI: begin
                ram_wr    = 1'b1;
                ram_addr  = ADDR_W'(loc_off + OFF_W'(1));
                ram_wdata = ram_rdata ^ loc_hi;
                if (r_q.cur == '0) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.cur = r_q.cur - SEL_W'(1);
                    r_d.st  = ST_RD_LO;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cur: '0, fail: 1'b0, idx: '0, msk: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done = (r_q.st == ST_FIN);
    assign fail = done && r_q.fail;
    assign busy = (r_q.st != ST_IDLE) && (r_q.st != ST_FIN);

endmodule

// File: rtl/rs_err_apply_chk.sv
module rs_err_apply_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              ram_rd,
    input logic              ram_wr,
    input logic [ADDR_W-1:0] ram_addr
);
    AST_RMW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> ($past(ram_rd) && $stable(ram_addr))); // R6
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done); // R2
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy || done)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ram_rd && !ram_wr)); // R10
endmodule

bind rs_err_apply rs_err_apply_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .fail    (fail),
    .ram_rd  (ram_rd),
    .ram_wr  (ram_wr),
    .ram_addr(ram_addr)
);

// File: tb/rs_err_apply_bench.sv
module rs_err_apply_bench;

    localparam int NB = 512;

    typedef struct packed {
        logic [2:0]  cnt;
        logic        unc;
        logic [35:0] idx;
        logic [35:0] msk;
        logic        efail;
        logic [3:0]  nwr;
        logic [9:0]  faddr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, {9'd0, 9'd0, 9'd0, 9'd1},       {9'h0, 9'h0, 9'h0, 9'h001},       1'b0, 4'd2, 10'd0},
        '{3'd2, 1'b0, {9'd0, 9'd0, 9'd200, 9'd10},    {9'h0, 9'h0, 9'h0A5, 9'h1FF},     1'b0, 4'd4, 10'd223},
        '{3'd4, 1'b0, {9'd455, 9'd300, 9'd16, 9'd8},  {9'h003, 9'h055, 9'h100, 9'h1FF}, 1'b0, 4'd8, 10'd510},
        '{3'd1, 1'b0, {9'd0, 9'd0, 9'd0, 9'd456},     {9'h0, 9'h0, 9'h0, 9'h1FF},       1'b0, 4'd1, 10'd511},
        '{3'd2, 1'b0, {9'd0, 9'd0, 9'd3, 9'd457},     {9'h0, 9'h0, 9'h0F0, 9'h1FF},     1'b0, 4'd2, 10'd2},
        '{3'd3, 1'b1, {9'd0, 9'd30, 9'd20, 9'd10},    {9'h0, 9'h001, 9'h001, 9'h001},   1'b1, 4'd0, 10'h3FF},
        '{3'd0, 1'b0, {9'd5, 9'd6, 9'd7, 9'd8},       {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF}, 1'b0, 4'd0, 10'h3FF},
        '{3'd7, 1'b0, {9'd0, 9'd60, 9'd40, 9'd20},    {9'h1FF, 9'h081, 9'h100, 9'h0AA}, 1'b0, 4'd6, 10'd66},
        '{3'd1, 1'b0, {9'd77, 9'd88, 9'd99, 9'd100},  {9'h1FF, 9'h1FF, 9'h1FF, 9'h024}, 1'b0, 4'd2, 10'd111}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  err_cnt = '0;
    logic        uncorr = 1'b0;
    logic [35:0] rep_idx = '0;
    logic [35:0] rep_mask = '0;
    logic        busy, done, fail, ram_rd, ram_wr;
    logic [8:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;

    logic [7:0]  mem     [NB];
    logic [7:0]  ref_mem [NB];
    int          wr_cnt = 0;
    logic [9:0]  wr_log  [64];
    int          n_checks = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    rs_err_apply u_rs_err_apply (
        .clk(clk), .rst_n(rst_n), .start(start), .err_cnt(err_cnt),
        .uncorr(uncorr), .rep_idx(rep_idx), .rep_mask(rep_mask),
        .busy(busy), .done(done), .fail(fail), .ram_addr(ram_addr),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    // Byte RAM model, one cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) mem[i] <= 8'((i * 7 + 3) & 255);
        end else begin
            if (ram_rd) ram_rdata <= mem[ram_addr];
            if (ram_wr) begin
                mem[ram_addr] <= ram_wdata;
                wr_log[wr_cnt % 64] <= {1'b0, ram_addr};
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference correction from the requirements (R4, R5, R7, R8)
    task automatic ref_apply(input logic [2:0] cnt, input logic unc,
                             input logic [35:0] idxv, input logic [35:0] mskv);
        int n;
        n = (cnt > 3'd4) ? 4 : int'(cnt);
        if (unc) return;
        for (int r = n - 1; r >= 0; r--) begin
            int p, off;
            logic [15:0] pat;
            p   = (int'(idxv[r*9 +: 9]) + 511) % 512;
            off = p + (p >> 3);
            pat = 16'(mskv[r*9 +: 9]) << (p % 8);
            if (off < NB) begin
                ref_mem[off] = ref_mem[off] ^ pat[7:0];
                if (off < NB - 1) ref_mem[off + 1] = ref_mem[off + 1] ^ pat[15:8];
            end
        end
    endtask

    function automatic int mem_diffs();
        int d = 0;
        for (int i = 0; i < NB; i++) if (mem[i] !== ref_mem[i]) d++;
        return d;
    endfunction

    task automatic kick(input logic [2:0] cnt, input logic unc,
                        input logic [35:0] idxv, input logic [35:0] mskv);
        err_cnt  = cnt;
        uncorr   = unc;
        rep_idx  = idxv;
        rep_mask = mskv;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int base, cyc;
        for (int i = 0; i < NB; i++) ref_mem[i] = 8'((i * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(!busy && !done && !fail && !ram_rd && !ram_wr, "R10 reset quiet",
              {busy, done, fail, ram_rd, ram_wr}, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            base = wr_cnt;
            kick(VECS[v].cnt, VECS[v].unc, VECS[v].idx, VECS[v].msk);
            wait_done(cyc);
            check(done === 1'b1, "R9 done reached", int'(done), 1);
            check(fail === VECS[v].efail, "R2 fail flag", int'(fail), int'(VECS[v].efail));
            ref_apply(VECS[v].cnt, VECS[v].unc, VECS[v].idx, VECS[v].msk);
            check(wr_cnt - base == int'(VECS[v].nwr), "R7 R8 write count",
                  wr_cnt - base, int'(VECS[v].nwr));
            if (VECS[v].nwr != 0)
                check(wr_log[base % 64] == VECS[v].faddr, "R4 R5 first write address",
                      int'(wr_log[base % 64]), int'(VECS[v].faddr));
            check(mem_diffs() == 0, "R5 R6 R3 buffer contents", mem_diffs(), 0);
            @(negedge clk);
            check(!done && !busy, "R9 done single cycle", int'(done), 0);
        end

        // R3: count 0 completes one cycle after start
        kick(3'd0, 1'b0, 36'd1, 36'h1FF);
        check(done && !fail && !busy, "R3 count zero latency", int'(done), 1);
        @(negedge clk);
        check(!done, "R9 done drops", int'(done), 0);

        // R2: uncorrectable completes one cycle after start with fail
        base = wr_cnt;
        kick(3'd4, 1'b1, {9'd1, 9'd2, 9'd3, 9'd4}, {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF});
        check(done && fail, "R2 uncorrectable latency", int'(fail), 1);
        @(negedge clk);
        check(wr_cnt == base, "R2 no writes", wr_cnt - base, 0);

        // R1 R9: inputs held, start ignored while busy
        base = wr_cnt;
        kick(3'd1, 1'b0, {27'd0, 9'd50}, {27'd0, 9'h00F});
        check(busy === 1'b1, "R9 busy after start", int'(busy), 1);
        err_cnt  = 3'd4;
        rep_idx  = {9'd60, 9'd70, 9'd80, 9'd90};
        rep_mask = {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF};
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        ref_apply(3'd1, 1'b0, {27'd0, 9'd50}, {27'd0, 9'h00F});
        check(wr_cnt - base == 2, "R1 write count", wr_cnt - base, 2);
        check(mem_diffs() == 0, "R1 latched inputs", mem_diffs(), 0);
        @(negedge clk);
        check(!busy && !done, "R1 no restart", int'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule